// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to eight interrupt request lines, remembers which ones have asked for service, filters them through a per-line mask and raises one interrupt output toward the processor when a request outranks every level already being serviced. Line 0 has the highest priority and line 7 the lowest, and the order is fixed. Requests are level sampled: an unmasked line that is high at a clock edge sets its pending bit, and that bit stays set until the level is acknowledged.

The processor answers the interrupt with three acknowledge pulses. The first pulse makes the winning level in-service, drops its pending bit and returns a call opcode. The second pulse returns the low byte of a handler address and the third pulse returns the high byte. The handler address is a programmed 16-bit base plus four bytes per level. Service can nest: a higher level may interrupt one already in service. Each in-service bit is released by an end-of-service command, or automatically on the third pulse when that option was chosen at setup.

Software reaches the block through a byte-wide port with a select, read and write strobes and one address bit. Every bus transaction and every acknowledge pulse lasts one clock. The requested byte appears on `rdata` at the following clock edge and stays there until the next transaction.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `int_out` is 0, `rdata` is 0, the pending, mask and in-service registers are all zero, automatic release is off and the status select points at the pending register.
- R2: A request line that is high and unmasked at a clock edge sets its pending bit. The bit stays set after the line drops, until the first acknowledge of that level clears it.
- R3: Writing a byte with `a0`=1 outside setup loads the mask register. A mask bit of 1 keeps its line from setting a pending bit. A masked higher-priority line never blocks an unmasked lower-priority one.
- R4: `int_out` is 1 exactly when no acknowledge sequence is in progress and the lowest-numbered unmasked pending level has a smaller number than every in-service level (or nothing is in service).
- R5: The first acknowledge pulse puts 8'hCD on `rdata` at the next edge. It sets the in-service bit of the winning level, clears that level's pending bit, and holds `int_out` at 0 until the third pulse has been taken.
- R6: The second pulse returns bits 7:0 and the third pulse returns bits 15:8 of (base + 4 × level), with carry into the high byte.
- R7: With automatic release enabled, the third pulse clears the in-service bit of the level being acknowledged.
- R8: A write with `a0`=0, bit 7 = 0 and bit 5 = 1 clears the lowest-numbered set in-service bit (end of service).
- R9: While a level is in service, a pending lower-priority request keeps `int_out` at 0 and a pending higher-priority request raises it. Several in-service bits may then be set together.
- R10: A write with `a0`=0 and bit 7 = 1 is the setup word. It clears the mask and in-service registers and takes automatic release from bit 0. The next two `a0`=1 writes load the base low byte and then the base high byte.
- R11: A write with `a0`=0, bit 7 = 0 and bit 5 = 0 sets the status select from bit 0. A read with `a0`=0 then returns the pending register (select 0) or the in-service register (select 1). A read with `a0`=1 returns the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Block select for bus accesses |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read or acknowledge data |
| irq_in | input | 8 | Request lines, bit 0 highest priority |
| ack | input | 1 | Acknowledge pulse, one cycle each |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending or mask bit shows on `int_out` one cycle after the request line is sampled, and on the pending status read one cycle after the read strobe. A wrong in-service bit, or a wrong level latched at the first pulse, shows in the handler address bytes on the second and third pulses. It also shows as `int_out` staying up or staying down when a nested request arrives. A failed release, whether automatic or by command, shows on the next in-service status read and as a lower level that cannot raise `int_out` afterwards. Sweeping every level through both release modes, with a base chosen so that the upper levels carry into the high byte, exposes each of these within a few cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LO   = 2'd1,
      PH_HI   = 2'd2
   } ack_phase_t;
endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irqc_ack_seq.sv
module irqc_ack_seq
   import irqc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic first_hit,
   output logic second_hit,
   output logic third_hit,
   output logic idle
);
   ack_phase_t ph;

   assign idle       = (ph == PH_IDLE);
   assign first_hit  = ack && (ph == PH_IDLE);
   assign second_hit = ack && (ph == PH_LO);
   assign third_hit  = ack && (ph == PH_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph <= PH_IDLE;
      end else if (ack) begin
         case (ph)
            PH_IDLE: ph <= PH_LO;
            PH_LO:   ph <= PH_HI;
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int          N_IRQ    = 8,
   parameter int          DW       = 8,
   parameter int          VEC_STEP = 4,
   parameter logic [7:0]  CALL_OP  = 8'hCD
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic          a0,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic          ack,
   output logic          int_out
);
   localparam int IW      = $clog2(N_IRQ);
   localparam int STEP_LG = $clog2(VEC_STEP);
   localparam int VW      = 2 * DW;
   localparam logic [N_IRQ-1:0] ONE = {{(N_IRQ-1){1'b0}}, 1'b1};

   initial begin
      assert (N_IRQ >= 2 && N_IRQ <= DW)
         else $error("N_IRQ must lie between 2 and DW");
      assert ((1 << STEP_LG) == VEC_STEP)
         else $error("VEC_STEP must be a power of two");
      assert (DW >= 8) else $error("DW must hold the call opcode");
   end

   logic [N_IRQ-1:0] irr, imr, isr, isr_nxt, pend;
   logic [VW-1:0]    base_q, vec;
   logic [IW-1:0]    lvl_q, pend_idx, isr_idx;
   logic             pend_any, isr_any, eligible;
   logic             aeoi, rsel;
   logic [1:0]       setup_cnt;
   logic             wr_hit, rd_hit, setup_wr, eoi_wr, sel_wr;
   logic             first_hit, second_hit, third_hit, seq_idle;
   logic [DW-1:0]    status;
   logic             unused_wbits;

   assign wr_hit   = sel && wr_en;
   assign rd_hit   = sel && rd_en;
   assign setup_wr = wr_hit && !a0 && wdata[7];
   assign eoi_wr   = wr_hit && !a0 && !wdata[7] && wdata[5];
   assign sel_wr   = wr_hit && !a0 && !wdata[7] && !wdata[5];
   assign unused_wbits = ^{wdata[6], wdata[4:1]};

   assign pend = irr & ~imr;

   irqc_prio_pick #(.N(N_IRQ), .IW(IW)) u_pick_pend (
      .req(pend), .any(pend_any), .idx(pend_idx));

   irqc_prio_pick #(.N(N_IRQ), .IW(IW)) u_pick_isr (
      .req(isr), .any(isr_any), .idx(isr_idx));

   irqc_ack_seq u_seq (
      .clk(clk), .rst_n(rst_n), .ack(ack),
      .first_hit(first_hit), .second_hit(second_hit),
      .third_hit(third_hit), .idle(seq_idle));

   assign eligible = pend_any && (!isr_any || (pend_idx < isr_idx));
   assign int_out  = seq_idle && eligible;
   assign vec      = base_q + (VW'(lvl_q) << STEP_LG);

   always_comb begin
      isr_nxt = isr;
      if (first_hit && pend_any) isr_nxt = isr_nxt | (ONE << pend_idx);
      if (third_hit && aeoi)     isr_nxt = isr_nxt & ~(ONE << lvl_q);
      if (eoi_wr && isr_any)     isr_nxt = isr_nxt & ~(ONE << isr_idx);
      if (setup_wr)              isr_nxt = '0;
   end

   always_comb begin
      status = '0;
      if (a0)        status[N_IRQ-1:0] = imr;
      else if (rsel) status[N_IRQ-1:0] = isr;
      else           status[N_IRQ-1:0] = irr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr       <= '0;
         imr       <= '0;
         isr       <= '0;
         base_q    <= '0;
         lvl_q     <= '0;
         aeoi      <= 1'b0;
         rsel      <= 1'b0;
         setup_cnt <= 2'd0;
         rdata     <= '0;
      end else begin
         isr <= isr_nxt;
         if (first_hit && pend_any)
            irr <= (irr | (irq_in & ~imr)) & ~(ONE << pend_idx);
         else
            irr <= irr | (irq_in & ~imr);
         if (first_hit) lvl_q <= pend_idx;

         if (setup_wr) begin
            aeoi      <= wdata[0];
            imr       <= '0;
            setup_cnt <= 2'd2;
         end else if (wr_hit && a0) begin
            if (setup_cnt == 2'd2) begin
               base_q[DW-1:0] <= wdata;
               setup_cnt      <= 2'd1;
            end else if (setup_cnt == 2'd1) begin
               base_q[VW-1:DW] <= wdata;
               setup_cnt       <= 2'd0;
            end else begin
               imr <= wdata[N_IRQ-1:0];
            end
         end else if (sel_wr) begin
            rsel <= wdata[0];
         end

         if (first_hit)       rdata <= DW'(CALL_OP);
         else if (second_hit) rdata <= vec[DW-1:0];
         else if (third_hit)  rdata <= vec[VW-1:DW];
         else if (rd_hit)     rdata <= status;
      end
   end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
   parameter int         N_IRQ   = 8,
   parameter int         DW      = 8,
   parameter logic [7:0] CALL_OP = 8'hCD
) (
   input logic             clk,
   input logic             rst_n,
   input logic             first_hit,
   input logic             wr_hit,
   input logic             int_out,
   input logic [DW-1:0]    rdata,
   input logic [N_IRQ-1:0] irq_in,
   input logic [N_IRQ-1:0] irr,
   input logic [N_IRQ-1:0] imr,
   input logic [N_IRQ-1:0] isr
);
   p_call_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
      first_hit |=> (rdata == DW'(CALL_OP)));

   p_int_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      first_hit |=> !int_out);

   p_isr_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (first_hit && !wr_hit && ((irr & ~imr) != '0))
         |=> ($countones(isr) == $countones($past(isr)) + 1));

   p_int_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr & ~imr) != '0));

   p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 ((irr & ~$past(irr) & ~$past(irq_in & ~imr)) == '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_IRQ(N_IRQ), .DW(DW), .CALL_OP(CALL_OP)) u_chk (
   .clk(clk), .rst_n(rst_n), .first_hit(first_hit), .wr_hit(wr_hit),
   .int_out(int_out), .rdata(rdata), .irq_in(irq_in),
   .irr(irr), .imr(imr), .isr(isr));

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0, a0 = 1'b0, ack = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] irq_in = '0;
   logic       int_out;
   int         n_chk = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;

   vec_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
      .a0(a0), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
      .ack(ack), .int_out(int_out));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic addr, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; a0 = addr; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0; a0 = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic addr, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; rd_en = 1'b1; a0 = addr;
      @(negedge clk);
      sel = 1'b0; rd_en = 1'b0; a0 = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(output logic [7:0] d);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      d = rdata;
   endtask

   task automatic setup(input logic auto_rel, input logic [15:0] base);
      wr(1'b0, {7'b1000000, auto_rel});
      wr(1'b1, base[7:0]);
      wr(1'b1, base[15:8]);
   endtask

   task automatic serve(input string req, input int lvl, input logic [15:0] base);
      logic [7:0]  b;
      logic [15:0] v;
      v = base + 16'(lvl * 4);
      pulse(b); check({req, " R5 call opcode"}, b, 8'hCD);
      check({req, " R5 int low in sequence"}, int_out, 0);
      pulse(b); check({req, " R6 vector low"}, b, v[7:0]);
      pulse(b); check({req, " R6 vector high"}, b, v[15:8]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 int_out", int_out, 0);
      check("R1 rdata", rdata, 0);
      rd(1'b0, b); check("R1 pending zero", b, 0);
      rd(1'b1, b); check("R1 mask zero", b, 0);

      // sweep every level, release by command (R2 R4 R5 R6 R8 R11)
      setup(1'b0, 16'h12F0);
      for (int k = 0; k < 8; k++) begin
         irq_in = 8'(1 << k);
         @(negedge clk);
         irq_in = '0;
         check("R4 int raised", int_out, 1);
         rd(1'b0, b); check("R2 pending latched", b, 1 << k);
         serve("sweep", k, 16'h12F0);
         rd(1'b0, b); check("R5 pending cleared", b, 0);
         wr(1'b0, 8'h01);
         rd(1'b0, b); check("R11 R5 in-service set", b, 1 << k);
         wr(1'b0, 8'h20);
         rd(1'b0, b); check("R8 in-service released", b, 0);
         wr(1'b0, 8'h00);
      end

      // nesting (R9, R8 lowest-numbered release)
      irq_in = 8'h20; @(negedge clk); irq_in = '0;
      serve("nest5", 5, 16'h12F0);
      irq_in = 8'h80; @(negedge clk); irq_in = '0;
      check("R9 lower blocked", int_out, 0);
      irq_in = 8'h04; @(negedge clk); irq_in = '0;
      check("R9 higher raises", int_out, 1);
      serve("nest2", 2, 16'h12F0);
      wr(1'b0, 8'h01);
      rd(1'b0, b); check("R9 two in service", b, 8'h24);
      check("R9 level 7 still held off", int_out, 0);
      wr(1'b0, 8'h20);
      rd(1'b0, b); check("R8 clears level 2 first", b, 8'h20);
      check("R9 7 below 5", int_out, 0);
      wr(1'b0, 8'h20);
      check("R4 int after last release", int_out, 1);
      serve("nest7", 7, 16'h12F0);
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h00);

      // mask (R3 R11)
      wr(1'b1, 8'h01);
      rd(1'b1, b); check("R11 mask read", b, 8'h01);
      irq_in = 8'h03; @(negedge clk); irq_in = '0;
      rd(1'b0, b); check("R3 masked line not latched", b, 8'h02);
      check("R3 lower not blocked", int_out, 1);
      serve("mask", 1, 16'h12F0);
      wr(1'b0, 8'h20);
      wr(1'b1, 8'hFF);
      irq_in = 8'hFF; @(negedge clk); irq_in = '0;
      check("R3 all masked", int_out, 0);
      rd(1'b0, b); check("R3 nothing pending", b, 0);

      // setup clears mask, automatic release sweep (R10 R7)
      setup(1'b1, 16'h00FE);
      rd(1'b1, b); check("R10 mask cleared", b, 0);
      for (int k = 0; k < 8; k++) begin
         irq_in = 8'(1 << k); @(negedge clk); irq_in = '0;
         check("R4 int raised auto", int_out, 1);
         serve("auto", k, 16'h00FE);
         wr(1'b0, 8'h01);
         rd(1'b0, b); check("R7 auto release", b, 0);
         wr(1'b0, 8'h00);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule